// File: doc/BRIEF.md
# Exception Return Frame Sequencer

This block carries out a return from an exception handler. Given a start pulse, the current stack pointer and the address of the return instruction, it reads the first longword of the exception frame. It checks the frame's 4-bit format code. When the code is acceptable, it fetches the return address from the second longword. It then commits the new status register, program counter and stack pointer in a single cycle.

When the format code is not acceptable, the block stops after the first read and reports a format error. It also reports the address of the return instruction, so that a separate fault unit can build its own frame. The stack and all architectural registers stay untouched in that case. A bus error on either read ends the sequence with an access-error indication, and nothing is committed.

The memory side is a plain read port. The request is held with a stable address until the port answers with ready, carrying data or an error. All results come out as one-cycle write-enable pulses, together with a done pulse.

Top module: `exc_return_seq`

## Requirements
- R1: After a synchronous reset, `mem_req_o`, `busy_o`, `done_o`, all write enables and both error flags are 0, and `sp_o`, `sr_o`, `pc_o`, `fault_pc_o` are 0.
- R2: A `start_i` seen while idle issues a read of the first longword at `sp_i` in the next cycle. The request stays high with an unchanged address until `mem_ready_i` is seen.
- R3: The format code is bits 31..28 of the first longword. Only the codes 4, 5, 6 and 7 are accepted, and for these the second longword is read from `sp_i + 4`.
- R4: Any other code (0..3, 8..15) gives a one-cycle `fmt_err_o` with `done_o`. `fault_pc_o` equals the `rte_pc_i` captured at start. No second read and no write enable occur. A legacy frame whose top half holds a status value with bit 30 clear (for example 0x2700_xxxx, code 2) is rejected this way.
- R5: On an accepted frame, `sr_o` is bits 15..0 of the first longword and `pc_o` is the second longword. `sp_o` is `sp_i + 4 + code`, wrapping modulo 2^AW. `sp_we_o`, `sr_we_o` and `pc_we_o` pulse together for one cycle with `done_o`.
- R6: `mem_err_i` with `mem_ready_i` on either read gives a one-cycle `acc_err_o` with `done_o`. No write enable follows, and there is no further read.
- R7: With a read latency of L extra cycles per read, `done_o` rises 4+2L cycles after the start edge for an accepted frame or a second-read bus error. It rises 3+L cycles after for a format error, and 2+L cycles after for a first-read bus error.
- R8: `start_i` while busy is ignored. No extra read is issued and the running sequence finishes unchanged.
- R9: `done_o` lasts exactly one cycle, and `fmt_err_o` and `acc_err_o` are never high together.
- R10: Reset in the middle of a sequence drops the request at once and commits nothing. A later start runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a return sequence |
| sp_i | input | AW | Stack pointer at start |
| rte_pc_i | input | AW | Address of the return instruction |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read address |
| mem_ready_i | input | 1 | Read response valid |
| mem_rdata_i | input | DW | Read data |
| mem_err_i | input | 1 | Bus error with the response |
| sp_we_o | output | 1 | Stack pointer write enable |
| sp_o | output | AW | New stack pointer |
| sr_we_o | output | 1 | Status register write enable |
| sr_o | output | SRW | New status register |
| pc_we_o | output | 1 | Program counter write enable (fetch redirect) |
| pc_o | output | AW | Return address |
| done_o | output | 1 | Sequence finished (one cycle) |
| fmt_err_o | output | 1 | Format error (one cycle, with done) |
| acc_err_o | output | 1 | Bus error on a read (one cycle, with done) |
| fault_pc_o | output | AW | Return instruction address for a fault |

## Verification
A wrong state shows at the ports within a few cycles. A stuck or skipped state moves `done_o` away from the 4+2L, 3+L or 2+L cycle counts. It can also issue a second read that should not exist, or drop one that should. A mis-taken branch in the format check shows on the same done cycle as a wrong error flag or a stray write enable. A wrong latched base or code shows as an `sp_o` or `pc_o` value that differs from the value computed from the frame words.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ1,
    ST_CHECK,
    ST_READ2,
    ST_COMMIT,
    ST_ERROR
  } rts_state_e;

  typedef enum logic [1:0] {
    FAULT_NONE,
    FAULT_FORMAT,
    FAULT_BUS
  } rts_fault_e;

  localparam int CODE_W = 4;
endpackage

// File: rtl/rts_frame_check.sv
module rts_frame_check #(
  parameter int DW     = 32,
  parameter int SRW    = 16,
  parameter int FMT_LO = 4,
  parameter int FMT_HI = 7
) (
  input  logic [DW-1:0]               word_i,
  output logic [rts_pkg::CODE_W-1:0]  fmt_o,
  output logic [SRW-1:0]              sr_o,
  output logic                        ok_o
);
  localparam int CW = rts_pkg::CODE_W;

  logic unused_mid;
  assign unused_mid = ^word_i[DW-CW-1:SRW];

  assign fmt_o = word_i[DW-1 -: CW];
  assign sr_o  = word_i[SRW-1:0];
  assign ok_o  = (int'(fmt_o) >= FMT_LO) && (int'(fmt_o) <= FMT_HI);
endmodule

// File: rtl/rts_commit_unit.sv
module rts_commit_unit #(
  parameter int AW  = 32,
  parameter int SRW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit_i,
  input  logic [AW-1:0]  sp_new_i,
  input  logic [SRW-1:0] sr_new_i,
  input  logic [AW-1:0]  pc_new_i,
  output logic           sp_we_o,
  output logic [AW-1:0]  sp_o,
  output logic           sr_we_o,
  output logic [SRW-1:0] sr_o,
  output logic           pc_we_o,
  output logic [AW-1:0]  pc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_we_o <= 1'b0;
      sr_we_o <= 1'b0;
      pc_we_o <= 1'b0;
      sp_o    <= '0;
      sr_o    <= '0;
      pc_o    <= '0;
    end else begin
      sp_we_o <= commit_i;
      sr_we_o <= commit_i;
      pc_we_o <= commit_i;
      if (commit_i) begin
        sp_o <= sp_new_i;
        sr_o <= sr_new_i;
        pc_o <= pc_new_i;
      end
    end
  end
endmodule

// File: rtl/exc_return_seq.sv
module exc_return_seq
  import rts_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SRW        = 16,
  parameter int FMT_LO     = 4,
  parameter int FMT_HI     = 7,
  parameter int FRAME_STEP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [AW-1:0]  sp_i,
  input  logic [AW-1:0]  rte_pc_i,
  output logic           busy_o,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic           mem_ready_i,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_err_i,
  output logic           sp_we_o,
  output logic [AW-1:0]  sp_o,
  output logic           sr_we_o,
  output logic [SRW-1:0] sr_o,
  output logic           pc_we_o,
  output logic [AW-1:0]  pc_o,
  output logic           done_o,
  output logic           fmt_err_o,
  output logic           acc_err_o,
  output logic [AW-1:0]  fault_pc_o
);
  localparam logic [AW-1:0] STEP = AW'(FRAME_STEP);

  rts_state_e         state_q;
  rts_fault_e         fault_q;
  logic [AW-1:0]      sp_base_q;
  logic [AW-1:0]      pc_ret_q;
  logic [AW-1:0]      addr_q;
  logic [DW-1:0]      word_q;
  logic [CODE_W-1:0]  fmt;
  logic [SRW-1:0]     sr_stage;
  logic               fmt_ok;
  logic [AW-1:0]      sp_next;
  logic               commit_go;

  rts_frame_check #(
    .DW(DW), .SRW(SRW), .FMT_LO(FMT_LO), .FMT_HI(FMT_HI)
  ) u_check (
    .word_i (word_q),
    .fmt_o  (fmt),
    .sr_o   (sr_stage),
    .ok_o   (fmt_ok)
  );

  assign sp_next   = sp_base_q + STEP + AW'(fmt);
  assign commit_go = (state_q == ST_READ2) && mem_ready_i && !mem_err_i;

  rts_commit_unit #(.AW(AW), .SRW(SRW)) u_commit (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit_go),
    .sp_new_i (sp_next),
    .sr_new_i (sr_stage),
    .pc_new_i (mem_rdata_i[AW-1:0]),
    .sp_we_o  (sp_we_o),
    .sp_o     (sp_o),
    .sr_we_o  (sr_we_o),
    .sr_o     (sr_o),
    .pc_we_o  (pc_we_o),
    .pc_o     (pc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      fault_q   <= FAULT_NONE;
      sp_base_q <= '0;
      pc_ret_q  <= '0;
      addr_q    <= '0;
      word_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sp_base_q <= sp_i;
            pc_ret_q  <= rte_pc_i;
            addr_q    <= sp_i;
            fault_q   <= FAULT_NONE;
            state_q   <= ST_READ1;
          end
        end
        ST_READ1: begin
          if (mem_ready_i) begin
            if (mem_err_i) begin
              fault_q <= FAULT_BUS;
              state_q <= ST_ERROR;
            end else begin
              word_q  <= mem_rdata_i;
              state_q <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (fmt_ok) begin
            addr_q  <= sp_base_q + STEP;
            state_q <= ST_READ2;
          end else begin
            fault_q <= FAULT_FORMAT;
            state_q <= ST_ERROR;
          end
        end
        ST_READ2: begin
          if (mem_ready_i) begin
            if (mem_err_i) begin
              fault_q <= FAULT_BUS;
              state_q <= ST_ERROR;
            end else begin
              state_q <= ST_COMMIT;
            end
          end
        end
        ST_COMMIT: state_q <= ST_IDLE;
        ST_ERROR:  state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req_o  = (state_q == ST_READ1) || (state_q == ST_READ2);
  assign mem_addr_o = addr_q;
  assign done_o     = (state_q == ST_COMMIT) || (state_q == ST_ERROR);
  assign fmt_err_o  = (state_q == ST_ERROR) && (fault_q == FAULT_FORMAT);
  assign acc_err_o  = (state_q == ST_ERROR) && (fault_q == FAULT_BUS);
  assign fault_pc_o = pc_ret_q;
endmodule

// File: rtl/exc_return_seq_chk.sv
module exc_return_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [AW-1:0] sp_i,
  input logic [AW-1:0] rte_pc_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ready_i,
  input logic          sp_we_o,
  input logic [AW-1:0] sp_o,
  input logic          sr_we_o,
  input logic          pc_we_o,
  input logic          done_o,
  input logic          fmt_err_o,
  input logic          acc_err_o,
  input logic [AW-1:0] fault_pc_o
);
  logic [AW-1:0] cap_sp;
  logic [AW-1:0] cap_pc;
  logic [AW-1:0] sp_delta;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_sp <= '0;
      cap_pc <= '0;
    end else if (start_i && !busy_o) begin
      cap_sp <= sp_i;
      cap_pc <= rte_pc_i;
    end
  end

  assign sp_delta = sp_o - cap_sp;

  assert_start_read_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (mem_req_o && mem_addr_o == $past(sp_i)));

  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_fault_pc_R4: assert property (@(posedge clk) disable iff (rst)
    fmt_err_o |-> (fault_pc_o == cap_pc && !sp_we_o));

  assert_commit_together_R5: assert property (@(posedge clk) disable iff (rst)
    (sp_we_o || sr_we_o || pc_we_o) |->
      (sp_we_o && sr_we_o && pc_we_o && done_o && !fmt_err_o && !acc_err_o));

  assert_sp_adjust_R5: assert property (@(posedge clk) disable iff (rst)
    sp_we_o |-> (sp_delta >= AW'(8) && sp_delta <= AW'(11)));

  assert_no_commit_on_bus_R6: assert property (@(posedge clk) disable iff (rst)
    acc_err_o |-> !(sp_we_o || sr_we_o || pc_we_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(fmt_err_o && acc_err_o));
endmodule

bind exc_return_seq exc_return_seq_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .sp_i       (sp_i),
  .rte_pc_i   (rte_pc_i),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_ready_i(mem_ready_i),
  .sp_we_o    (sp_we_o),
  .sp_o       (sp_o),
  .sr_we_o    (sr_we_o),
  .pc_we_o    (pc_we_o),
  .done_o     (done_o),
  .fmt_err_o  (fmt_err_o),
  .acc_err_o  (acc_err_o),
  .fault_pc_o (fault_pc_o)
);

// File: tb/exc_return_seq_tb_top.sv
module exc_return_seq_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SRW = 16;

  typedef struct packed {
    logic [31:0] sp;
    logic [31:0] w1;
    logic [31:0] w2;
    logic [3:0]  lat;
    logic [1:0]  err_at;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 32'h4000_2704, 32'h0000_8000, 4'd0, 2'd0},
    '{32'h0000_2000, 32'h7000_0010, 32'h1234_5678, 4'd2, 2'd0},
    '{32'h0000_3000, 32'h5000_A5A5, 32'hCAFE_0000, 4'd1, 2'd0},
    '{32'h0000_4000, 32'h6000_FFFF, 32'h0000_0100, 4'd3, 2'd0},
    '{32'h0000_5000, 32'h3000_2700, 32'h1111_1111, 4'd0, 2'd0},
    '{32'h0000_6000, 32'h8000_0000, 32'h2222_2222, 4'd1, 2'd0},
    '{32'h0000_7000, 32'h2700_1000, 32'h3333_3333, 4'd0, 2'd0},
    '{32'h0000_8000, 32'hF000_0001, 32'h4444_4444, 4'd2, 2'd0},
    '{32'h0000_9000, 32'h0000_0000, 32'h5555_5555, 4'd0, 2'd0},
    '{32'h0000_A000, 32'h4000_0001, 32'h6666_6666, 4'd2, 2'd1},
    '{32'h0000_B000, 32'h6000_0002, 32'h7777_7777, 4'd1, 2'd2},
    '{32'hFFFF_FFF8, 32'h7000_1234, 32'h0ABC_DEF0, 4'd0, 2'd0}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start_i = 1'b0;
  logic [AW-1:0]  sp_i = '0;
  logic [AW-1:0]  rte_pc_i = '0;
  logic           busy_o, mem_req_o;
  logic [AW-1:0]  mem_addr_o;
  logic           mem_ready_i = 1'b0;
  logic [DW-1:0]  mem_rdata_i = '0;
  logic           mem_err_i = 1'b0;
  logic           sp_we_o, sr_we_o, pc_we_o;
  logic [AW-1:0]  sp_o, pc_o, fault_pc_o;
  logic [SRW-1:0] sr_o;
  logic           done_o, fmt_err_o, acc_err_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] cur_sp = '0, m0 = '0, m1 = '0;
  int          cur_lat = 0;
  int          cur_err = 0;
  int          rd_cnt = 0;
  int          we_cnt = 0;
  logic [31:0] rd_addr [4];

  always #10 clk = ~clk;

  exc_return_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sp_i(sp_i), .rte_pc_i(rte_pc_i),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i), .mem_err_i(mem_err_i),
    .sp_we_o(sp_we_o), .sp_o(sp_o), .sr_we_o(sr_we_o), .sr_o(sr_o),
    .pc_we_o(pc_we_o), .pc_o(pc_o), .done_o(done_o), .fmt_err_o(fmt_err_o),
    .acc_err_o(acc_err_o), .fault_pc_o(fault_pc_o)
  );

  // memory responder: answers after cur_lat waiting cycles
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (sp_we_o || sr_we_o || pc_we_o) we_cnt++;
      if (mem_req_o && !rst) begin
        if (wcnt == cur_lat) begin
          mem_ready_i = 1'b1;
          mem_rdata_i = (mem_addr_o == cur_sp) ? m0 :
                        (mem_addr_o == cur_sp + 32'd4) ? m1 : 32'hDEAD_BEEF;
          mem_err_i   = (cur_err == 1 && mem_addr_o == cur_sp) ||
                        (cur_err == 2 && mem_addr_o == cur_sp + 32'd4);
          if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr_o;
          rd_cnt++;
          wcnt = 0;
        end else begin
          mem_ready_i = 1'b0;
          mem_err_i   = 1'b0;
          wcnt++;
        end
      end else begin
        mem_ready_i = 1'b0;
        mem_err_i   = 1'b0;
        wcnt = 0;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one return sequence: start, wait for done, compare with computed values
  task automatic run_vec(input vec_t v, input logic [31:0] rpc, input bit poke_busy);
    logic [3:0]  code;
    bit          ok;
    int          cyc;
    int          exp_cyc;
    cur_sp  = v.sp; m0 = v.w1; m1 = v.w2;
    cur_lat = int'(v.lat); cur_err = int'(v.err_at);
    rd_cnt = 0; we_cnt = 0;
    code = v.w1[31:28];
    ok   = (code >= 4'd4) && (code <= 4'd7);
    @(negedge clk);
    start_i = 1'b1; sp_i = v.sp; rte_pc_i = rpc;
    @(negedge clk);
    start_i = 1'b0; sp_i = 32'h0BAD_0000; rte_pc_i = 32'h0BAD_0000;
    cyc = 1;
    while (!done_o && cyc < 60) begin
      if (poke_busy && cyc == 2) start_i = 1'b1;   // R8: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    if (cur_err == 1)      exp_cyc = 2 + cur_lat;
    else if (!ok)          exp_cyc = 3 + cur_lat;
    else                   exp_cyc = 4 + 2 * cur_lat;
    chk("R7", "done latency", 32'(cyc), 32'(exp_cyc));
    chk("R1", "done seen", {31'd0, done_o}, 32'd1);
    chk("R2", "first read addr", rd_addr[0], v.sp);
    if (cur_err != 0) begin
      chk("R6", "acc_err", {31'd0, acc_err_o}, 32'd1);
      chk("R9", "fmt_err low on bus err", {31'd0, fmt_err_o}, 32'd0);
    end else if (!ok) begin
      chk("R4", "fmt_err", {31'd0, fmt_err_o}, 32'd1);
      chk("R4", "fault pc", fault_pc_o, rpc);
      chk("R9", "acc_err low on fmt err", {31'd0, acc_err_o}, 32'd0);
    end else begin
      chk("R5", "sp_we", {31'd0, sp_we_o}, 32'd1);
      chk("R5", "sr_we", {31'd0, sr_we_o}, 32'd1);
      chk("R5", "pc_we", {31'd0, pc_we_o}, 32'd1);
      chk("R5", "new sp", sp_o, v.sp + 32'd4 + {28'd0, code});
      chk("R5", "new sr", {16'd0, sr_o}, {16'd0, v.w1[15:0]});
      chk("R5", "new pc", pc_o, v.w2);
      chk("R3", "second read addr", rd_addr[1], v.sp + 32'd4);
    end
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9", "done one cycle", {31'd0, done_o}, 32'd0);
    chk("R8", "idle after run", {31'd0, busy_o}, 32'd0);
    if (cur_err == 1)      chk("R6", "read count", 32'(rd_cnt), 32'd1);
    else if (!ok)          chk("R4", "read count", 32'(rd_cnt), 32'd1);
    else                   chk("R3", "read count", 32'(rd_cnt), 32'd2);
    if (ok && cur_err == 0) chk("R5", "write pulses", 32'(we_cnt), 32'd1);
    else if (cur_err != 0)  chk("R6", "write pulses", 32'(we_cnt), 32'd0);
    else                    chk("R4", "write pulses", 32'(we_cnt), 32'd0);
  endtask

  // watchdog
  initial begin
    #(20 * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "mem_req", {31'd0, mem_req_o}, 32'd0);
    chk("R1", "busy", {31'd0, busy_o}, 32'd0);
    chk("R1", "done", {31'd0, done_o}, 32'd0);
    chk("R1", "we", {29'd0, sp_we_o, sr_we_o, pc_we_o}, 32'd0);
    chk("R1", "errs", {30'd0, fmt_err_o, acc_err_o}, 32'd0);
    chk("R1", "sp_o", sp_o, 32'd0);
    chk("R1", "pc_o", pc_o, 32'd0);
    chk("R1", "sr_o", {16'd0, sr_o}, 32'd0);
    chk("R1", "fault_pc", fault_pc_o, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], 32'h0010_0000 + 32'(i * 2), 1'b0);
    end

    // R8: start pulse while busy is ignored
    run_vec('{32'h0000_C000, 32'h5000_0055, 32'h0000_C0DE, 4'd2, 2'd0},
            32'h0020_0000, 1'b1);

    // R10: reset in the middle of a long read
    cur_sp = 32'h0000_D000; m0 = 32'h4000_0000; m1 = 32'h0;
    cur_lat = 8; cur_err = 0; we_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; sp_i = 32'h0000_D000;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", "request held while waiting", {31'd0, mem_req_o}, 32'd1);
    chk("R2", "address stable", mem_addr_o, 32'h0000_D000);
    rst = 1'b1;
    @(negedge clk);
    chk("R10", "req dropped", {31'd0, mem_req_o}, 32'd0);
    chk("R10", "busy dropped", {31'd0, busy_o}, 32'd0);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk("R10", "no writes after reset", 32'(we_cnt), 32'd0);
    chk("R10", "no done after reset", {31'd0, done_o}, 32'd0);
    run_vec('{32'h0000_E000, 32'h6000_1357, 32'h0000_E0E0, 4'd0, 2'd0},
            32'h0030_0000, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule